// File: doc/BRIEF.md
# Dual-Pattern Serial Sequence Detector

This block watches a one-bit serial stream, taking one bit on each rising clock edge, and raises a one-bit flag whenever the three most recent bits match either of two fixed target patterns. Read oldest first, the targets are `0,0,1` and `1,1,0`. One shared state machine recognises both patterns. Its states hold the last two bits received. Extra start states cover the cycles after reset, when fewer than two bits have arrived.

The window slides by one bit per clock, so matches may overlap and a bit can close one match and open the next. The flag is registered. It is valid in the cycle after the edge that sampled the bit closing the window. The default parameters set the two target patterns, and the window width is fixed at three bits.

Top module: `dual_pattern_detector`

## Requirements
- R1: In the cycle after any clock edge where `rst` is high, `hit_o` is 0 and the machine has no bit history.
- R2: When the bits sampled on three consecutive edges are 0 then 0 then 1, `hit_o` is 1 in the cycle after the edge that sampled the 1.
- R3: When the bits sampled on three consecutive edges are 1 then 1 then 0, `hit_o` is 1 in the cycle after the edge that sampled the 0.
- R4: For each of the other six three-bit windows (000, 010, 011, 100, 101, 111, oldest bit first), `hit_o` is 0 in the cycle after the closing edge.
- R5: Until three bits have been sampled since reset, `hit_o` stays 0, and bits taken before reset never count toward a window.
- R6: Overlapping matches are all reported: the stream 0,0,1,1,0 gives `hit_o` of 0,0,1,0,1 after the successive edges, and the stream 1,1,0,0,1 does the same.
- R7: When `rst` is high on the same edge as a bit that would complete a match, reset wins: `hit_o` is 0 afterwards and that bit is discarded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock; one serial bit is taken per edge |
| rst | input | 1 | Synchronous active-high reset |
| bit_i | input | 1 | Serial data bit |
| hit_o | output | 1 | Registered flag: the last three bits match a target pattern |

## Verification
A completing bit and reset can arrive on the same edge. The bench provokes this by bringing the machine to a two-bit history of 0,0, then raising `rst` while it drives a 1. It expects `hit_o` low after that edge and a fresh history after it, so the next single 1 must not flag. A second collision comes from overlap, where the closing bit of one pattern is also the first bit of the other. Streams that chain the two patterns back to back check this, and a long pseudo-random stream is compared, edge by edge, against a three-bit shift-register model kept in the bench.

// File: rtl/seqdet_pkg.sv
package seqdet_pkg;

  localparam int WIN_W = 3;
  localparam int HIST_W = WIN_W - 1;

  // Start states for a partial history, then one state per two-bit history
  typedef enum logic [2:0] {
    ST_EMPTY = 3'd0,
    ST_S0    = 3'd1,
    ST_S1    = 3'd2,
    ST_H00   = 3'd4,
    ST_H01   = 3'd5,
    ST_H10   = 3'd6,
    ST_H11   = 3'd7
  } seq_state_t;

  function automatic logic is_full(input seq_state_t s);
    return (s == ST_H00) || (s == ST_H01) || (s == ST_H10) || (s == ST_H11);
  endfunction

  // Two remembered bits, older bit in the MSB
  function automatic logic [HIST_W-1:0] hist_bits(input seq_state_t s);
    logic [HIST_W-1:0] h;
    case (s)
      ST_H00:  h = 2'b00;
      ST_H01:  h = 2'b01;
      ST_H10:  h = 2'b10;
      ST_H11:  h = 2'b11;
      default: h = 2'b00;
    endcase
    return h;
  endfunction

  function automatic seq_state_t full_state(input logic [HIST_W-1:0] h);
    seq_state_t s;
    case (h)
      2'b00:   s = ST_H00;
      2'b01:   s = ST_H01;
      2'b10:   s = ST_H10;
      default: s = ST_H11;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/seqdet_history.sv
module seqdet_history
  import seqdet_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       bit_i,
  output seq_state_t state_o
);

  seq_state_t cur_q;
  seq_state_t nxt;

  always_comb begin
    case (cur_q)
      ST_EMPTY: nxt = bit_i ? ST_S1 : ST_S0;
      ST_S0:    nxt = bit_i ? ST_H01 : ST_H00;
      ST_S1:    nxt = bit_i ? ST_H11 : ST_H10;
      ST_H00, ST_H01, ST_H10, ST_H11:
                nxt = full_state({hist_bits(cur_q)[0], bit_i});
      default:  nxt = ST_EMPTY;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) cur_q <= ST_EMPTY;
    else     cur_q <= nxt;
  end

  assign state_o = cur_q;

  // R1
  rst_empty_chk: assert property (@(posedge clk) rst |=> (cur_q == ST_EMPTY));

  // R5
  start_walk_chk: assert property (@(posedge clk) disable iff (rst)
    (cur_q == ST_EMPTY) |=> (cur_q == ST_S0 || cur_q == ST_S1));

endmodule

// File: rtl/seqdet_match.sv
module seqdet_match
  import seqdet_pkg::*;
#(
  parameter int NPAT = 2,
  parameter logic [NPAT-1:0][WIN_W-1:0] PATS = {3'b110, 3'b001}
)(
  input  logic       clk,
  input  logic       rst,
  input  seq_state_t state_i,
  input  logic       bit_i,
  output logic       hit_o
);

  logic [WIN_W-1:0] window;
  logic [NPAT-1:0]  pat_hit;
  logic             hit_d;
  logic             hit_q;

  assign window = {hist_bits(state_i), bit_i};

  for (genvar p = 0; p < NPAT; p++) begin : g_pat
    assign pat_hit[p] = (window == PATS[p]);
  end

  assign hit_d = is_full(state_i) && (|pat_hit);

  always_ff @(posedge clk) begin
    if (rst) hit_q <= 1'b0;
    else     hit_q <= hit_d;
  end

  assign hit_o = hit_q;

  // R1
  rst_hit_chk: assert property (@(posedge clk) rst |=> !hit_q);

endmodule

// File: rtl/dual_pattern_detector.sv
module dual_pattern_detector
  import seqdet_pkg::*;
#(
  parameter logic [WIN_W-1:0] PAT_A = 3'b001,
  parameter logic [WIN_W-1:0] PAT_B = 3'b110
)(
  input  logic clk,
  input  logic rst,
  input  logic bit_i,
  output logic hit_o
);

  seq_state_t st;

  seqdet_history u_hist (
    .clk     (clk),
    .rst     (rst),
    .bit_i   (bit_i),
    .state_o (st)
  );

  seqdet_match #(
    .NPAT (2),
    .PATS ({PAT_B, PAT_A})
  ) u_match (
    .clk     (clk),
    .rst     (rst),
    .state_i (st),
    .bit_i   (bit_i),
    .hit_o   (hit_o)
  );

  // R2
  pat_a_chk: assert property (@(posedge clk) disable iff (rst)
    (st == ST_H00 && bit_i) |=> hit_o);

  // R3
  pat_b_chk: assert property (@(posedge clk) disable iff (rst)
    (st == ST_H11 && !bit_i) |=> hit_o);

  // R4
  no_false_chk: assert property (@(posedge clk) disable iff (rst)
    ((st == ST_H01) || (st == ST_H10) || (st == ST_H00 && !bit_i)
     || (st == ST_H11 && bit_i)) |=> !hit_o);

  // R5
  partial_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (!is_full(st)) |=> !hit_o);

endmodule

// File: tb/tb_dual_pattern_detector.sv
module tb_dual_pattern_detector;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bit_i = 1'b0;
  logic hit_o;

  int n_cmp = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  dual_pattern_detector dut (
    .clk   (clk),
    .rst   (rst),
    .bit_i (bit_i),
    .hit_o (hit_o)
  );

  task automatic check(input logic exp, input string req);
    n_cmp++;
    if (hit_o !== exp) begin
      n_bad++;
      $display("FAIL %s: hit_o=%b expected=%b at %0t", req, hit_o, exp, $time);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    @(posedge clk); #2;
    rst = 1'b0;
  endtask

  task automatic push(input logic b, input logic exp, input string req);
    bit_i = b;
    @(posedge clk); #2;
    check(exp, req);
  endtask

  task automatic t_reset();
    bit_i = 1'b1;
    do_reset();
    check(1'b0, "R1");
  endtask

  task automatic t_pat_a();
    do_reset();
    push(1'b0, 1'b0, "R5");
    push(1'b0, 1'b0, "R5");
    push(1'b1, 1'b1, "R2");
  endtask

  task automatic t_pat_b();
    do_reset();
    push(1'b1, 1'b0, "R5");
    push(1'b1, 1'b0, "R5");
    push(1'b0, 1'b1, "R3");
  endtask

  task automatic t_all_windows();
    for (int w = 0; w < 8; w++) begin
      logic [2:0] win;
      logic e;
      win = 3'(w);
      e = (win == 3'b001) || (win == 3'b110);
      do_reset();
      push(win[2], 1'b0, "R5");
      push(win[1], 1'b0, "R5");
      push(win[0], e, e ? "R2/R3 window" : "R4");
    end
  endtask

  task automatic t_overlap();
    logic [4:0] s1 = 5'b00110;
    logic [4:0] s2 = 5'b11001;
    logic [4:0] ex = 5'b00101;
    do_reset();
    for (int i = 4; i >= 0; i--) push(s1[i], ex[i], "R6");
    do_reset();
    for (int i = 4; i >= 0; i--) push(s2[i], ex[i], "R6");
  endtask

  task automatic t_reset_collision();
    do_reset();
    push(1'b0, 1'b0, "R5");
    push(1'b0, 1'b0, "R5");
    rst = 1'b1;
    bit_i = 1'b1;
    @(posedge clk); #2;
    rst = 1'b0;
    check(1'b0, "R7");
    push(1'b1, 1'b0, "R7");
    push(1'b0, 1'b0, "R5");
    push(1'b0, 1'b0, "R4");
    push(1'b1, 1'b1, "R2");
  endtask

  task automatic t_stream();
    logic [7:0] lfsr = 8'hA5;
    logic [2:0] win = 3'b000;
    int cnt = 0;
    do_reset();
    for (int i = 0; i < 300; i++) begin
      logic b;
      logic e;
      b = lfsr[0];
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      win = {win[1:0], b};
      if (cnt < 3) cnt++;
      e = (cnt >= 3) && ((win == 3'b001) || (win == 3'b110));
      push(b, e, "R6 stream");
    end
  endtask

  initial begin
    #(8 * 200000);
    n_bad++;
    $display("FAIL watchdog: run did not end, actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    @(posedge clk); #2;
    t_reset();
    t_pat_a();
    t_pat_b();
    t_all_windows();
    t_overlap();
    t_reset_collision();
    t_stream();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule